// File: doc/BRIEF.md
# Multimode Asynchronous Serial Port

This block is a full-duplex asynchronous serial port. Software drives it through a small register bus. It is meant for a microcontroller subsystem that needs plain 8-bit links and also 9-bit links shared by several nodes. In a shared link the ninth bit marks an address frame. A two-bit mode field selects the frame format. Software sends a frame by writing its payload to the data buffer address. Hardware raises sticky completion flags in the control/status register, and software clears them.

Timing comes from an external tick, `os_tick`. A rate register holds a doubling bit. When that bit is set, every tick is an oversampling strobe. When it is clear, only every second tick is. Each bit lasts 16 strobes. The receiver waits for a falling edge on the line. It then takes three samples around mid-bit and votes. A start bit that does not stay low by mid-bit is thrown away.

When the multiprocessor filter is enabled, a frame can be dropped instead of stored: in a 9-bit mode when its ninth bit is 0, and in the 8-bit mode when its stop bit is 0. A frame is also dropped while the receive flag is still set, so an unread byte is never overwritten.

Top module: `mmserial_port`

## Requirements
- R1: After reset the control/status register (address 0), the receive buffer (address 1) and the rate register (address 2) read 0, and `ser_tx` is high.
- R2: Control bits [7:6] hold the mode: 01 gives an 8-bit frame, 10 and 11 give a 9-bit frame. A sent frame is a 0 start bit, then the data LSB first, then control bit 3 as the ninth bit (9-bit modes only), then a 1 stop bit. The line stays high when idle.
- R3: A write to address 1 starts a frame only if the transmitter is idle and the mode is not 00. A write while busy, or in mode 00, has no effect on the line.
- R4: Control bit 1 (transmit-done) is set at the end of the stop bit. It stays set until software writes 0 to it.
- R5: When a received frame is accepted, its data byte goes to the buffer at address 1 and control bit 0 (receive-done) is set. That bit stays set until software writes 0 to it.
- R6: On acceptance, control bit 2 takes the received ninth bit in a 9-bit mode, or the received stop bit in mode 01.
- R7: With control bit 4 (receive-enable) clear, or with mode 00, no frame is accepted.
- R8: With control bit 5 (multiprocessor filter) set, a 9-bit frame is accepted only if its ninth bit is 1, and an 8-bit frame only if its stop bit is 1. Dropped frames change neither the buffer nor the flags.
- R9: A frame that completes while receive-done is set is dropped, and the buffer keeps its old value.
- R10: A start edge whose majority of samples 7, 8 and 9 (of 16) is high is rejected, and no frame is received.
- R11: Rate register bit 0 set makes every `os_tick` an oversampling strobe, giving a 16-tick bit. Clear gives a 32-tick bit.
- R12: Each received bit is the majority of its three mid-bit samples, so a single-sample glitch inside a bit does not change the data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | Rate tick from the baud source |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control/status, 1 data buffer, 2 rate |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| ser_rx | input | 1 | Serial receive line |
| ser_tx | output | 1 | Serial transmit line |

## Verification
The bench sweeps every byte value through the 8-bit mode, and many values with both ninth-bit polarities through the 9-bit modes. It decodes the line independently and compares the loopback result. A design that sends the ninth bit in the wrong slot, or stores the stop bit in place of the ninth, fails on half the sweep. Directed cases cover the following:
- A short start pulse, which a receiver without mid-bit validation would turn into a spurious frame.
- A one-clock glitch in every data bit, which a single-sample receiver would corrupt.
- Filtered and overrun frames, which a faulty design would let overwrite the buffer.
- A write while busy, which would restart the frame.
- The halved rate, which shows up as a wrong start-bit length.

// File: rtl/mmser_pkg.sv
package mmser_pkg;

    localparam int DATA_W    = 8;
    localparam int FRAME_MAX = DATA_W + 3;   // start + data + ninth + stop

    typedef enum logic [1:0] {
        MODE_OFF  = 2'b00,
        MODE_8BIT = 2'b01,
        MODE_9A   = 2'b10,
        MODE_9B   = 2'b11
    } mode_e;

    // Control/status register, MSB first
    typedef struct packed {
        mode_e mode;
        logic  mp_en;
        logic  rx_en;
        logic  tx_ninth;
        logic  rx_ninth;
        logic  tx_done;
        logic  rx_done;
    } ctrl_t;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              ninth;
        logic              stop;
    } rx_word_t;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_BUF  = 2'd1;
    localparam logic [1:0] A_RATE = 2'd2;

    function automatic logic has_ninth(mode_e m);
        return (m == MODE_9A) || (m == MODE_9B);
    endfunction

    function automatic logic vote3(logic a, logic b, logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/mmser_tx.sv
module mmser_tx
    import mmser_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              osr_en,
    input  logic              start,
    input  logic              nine,
    input  logic              tb8,
    input  logic [DATA_W-1:0] data,
    output logic              txd,
    output logic              busy,
    output logic              done
);
    localparam int CNT_W = $clog2(OSR);
    localparam int BIT_W = $clog2(FRAME_MAX + 1);

    logic [FRAME_MAX-1:0] shreg;
    logic [CNT_W-1:0]     cnt;
    logic [BIT_W-1:0]     left;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '1;
            cnt   <= '0;
            left  <= '0;
            busy  <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                shreg <= {1'b1, (nine ? tb8 : 1'b1), data, 1'b0};
                left  <= nine ? BIT_W'(FRAME_MAX) : BIT_W'(FRAME_MAX - 1);
                cnt   <= '0;
                busy  <= 1'b1;
            end else if (busy && osr_en) begin
                if (cnt == CNT_W'(OSR - 1)) begin
                    cnt   <= '0;
                    shreg <= {1'b1, shreg[FRAME_MAX-1:1]};
                    left  <= left - 1'b1;
                    if (left == BIT_W'(1)) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    assign txd = shreg[0];

    p_idle_high_r2: assert property (@(posedge clk) disable iff (rst)
        !busy |-> txd);

    p_done_ends_r4: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && txd));

endmodule

// File: rtl/mmser_rx.sv
module mmser_rx
    import mmser_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     osr_en,
    input  logic     en,
    input  logic     nine,
    input  logic     rxd,
    output logic     valid,
    output rx_word_t word
);
    localparam int CNT_W = $clog2(OSR);
    localparam int IDX_W = $clog2(DATA_W + 1);
    localparam int MID   = OSR / 2;

    rx_state_e        state;
    logic [CNT_W-1:0] cnt;
    logic [IDX_W-1:0] idx;
    logic [1:0]       samp;
    logic [DATA_W:0]  shreg;
    logic             stop_q;
    logic             meta, rxd_s;
    logic             vote;
    logic [IDX_W-1:0] last_idx;

    assign vote     = vote3(samp[1], samp[0], rxd_s);
    assign last_idx = nine ? IDX_W'(DATA_W) : IDX_W'(DATA_W - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            meta  <= 1'b1;
            rxd_s <= 1'b1;
        end else begin
            meta  <= rxd;
            rxd_s <= meta;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= RX_IDLE;
            cnt    <= '0;
            idx    <= '0;
            samp   <= '0;
            shreg  <= '0;
            stop_q <= 1'b0;
            valid  <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (!en) begin
                state <= RX_IDLE;
            end else if (osr_en) begin
                if (state == RX_IDLE) begin
                    if (!rxd_s) begin
                        state <= RX_START;
                        cnt   <= '0;
                    end
                end else begin
                    cnt <= (cnt == CNT_W'(OSR - 1)) ? '0 : cnt + 1'b1;
                    if (cnt == CNT_W'(MID - 1) || cnt == CNT_W'(MID))
                        samp <= {samp[0], rxd_s};
                    if (cnt == CNT_W'(MID + 1)) begin
                        if (state == RX_START) begin
                            if (vote) state <= RX_IDLE;
                        end else if (state == RX_DATA) begin
                            shreg[idx] <= vote;
                        end else begin
                            stop_q <= vote;
                            valid  <= 1'b1;
                            state  <= RX_IDLE;
                        end
                    end
                    if (cnt == CNT_W'(OSR - 1)) begin
                        if (state == RX_START) begin
                            state <= RX_DATA;
                            idx   <= '0;
                        end else if (state == RX_DATA) begin
                            if (idx == last_idx) state <= RX_STOP;
                            else idx <= idx + 1'b1;
                        end
                    end
                end
            end
        end
    end

    assign word.data  = shreg[DATA_W-1:0];
    assign word.ninth = shreg[DATA_W];
    assign word.stop  = stop_q;

    p_rx_off_r7: assert property (@(posedge clk) disable iff (rst)
        !en |=> (state == RX_IDLE && !valid));

    p_valid_after_stop_r5: assert property (@(posedge clk) disable iff (rst)
        valid |-> $past(state) == RX_STOP);

endmodule

// File: rtl/mmser_regs.sv
module mmser_regs
    import mmser_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              we,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              tx_busy,
    input  logic              tx_done,
    input  logic              rx_valid,
    input  rx_word_t          rx_word,
    output ctrl_t             ctrl,
    output logic [DATA_W-1:0] rdata,
    output logic              tx_start,
    output logic              osr_en
);
    ctrl_t             ctrl_n;
    logic [DATA_W-1:0] rxbuf;
    logic              dbl, half;
    logic              nine, accept;

    assign nine   = has_ninth(ctrl.mode);
    assign accept = rx_valid && ctrl.rx_en && !ctrl.rx_done &&
                    (!ctrl.mp_en || (nine ? rx_word.ninth : rx_word.stop));
    assign osr_en   = tick && (dbl || half);
    assign tx_start = we && (addr == A_BUF) && !tx_busy && (ctrl.mode != MODE_OFF);

    always_comb begin
        ctrl_n = ctrl;
        if (we && addr == A_CTRL) ctrl_n = ctrl_t'(wdata);
        if (tx_done) ctrl_n.tx_done = 1'b1;
        if (accept) begin
            ctrl_n.rx_done  = 1'b1;
            ctrl_n.rx_ninth = nine ? rx_word.ninth : rx_word.stop;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl  <= '0;
            rxbuf <= '0;
            dbl   <= 1'b0;
            half  <= 1'b0;
        end else begin
            ctrl <= ctrl_n;
            if (tick) half <= ~half;
            if (we && addr == A_RATE) dbl <= wdata[0];
            if (accept) rxbuf <= rx_word.data;
        end
    end

    always_comb begin
        case (addr)
            A_CTRL:  rdata = ctrl;
            A_BUF:   rdata = rxbuf;
            A_RATE:  rdata = {{(DATA_W-1){1'b0}}, dbl};
            default: rdata = '0;
        endcase
    end

    p_ti_sticky_r4: assert property (@(posedge clk) disable iff (rst)
        (ctrl.tx_done && !(we && addr == A_CTRL)) |=> ctrl.tx_done);

    p_ri_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        (ctrl.rx_done && !(we && addr == A_CTRL)) |=> ctrl.rx_done);

    p_hold_full_r9: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && ctrl.rx_done) |=> $stable(rxbuf));

    p_mp_filter_r8: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && ctrl.mp_en && nine && !rx_word.ninth) |=> $stable(rxbuf));

endmodule

// File: rtl/mmserial_port.sv
module mmserial_port
    import mmser_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       os_tick,
    input  logic       reg_we,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       ser_rx,
    output logic       ser_tx
);
    ctrl_t    ctrl;
    logic     osr_en, tx_start, tx_busy, tx_done, rx_valid;
    rx_word_t rx_word;

    mmser_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .tick     (os_tick),
        .we       (reg_we),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .tx_busy  (tx_busy),
        .tx_done  (tx_done),
        .rx_valid (rx_valid),
        .rx_word  (rx_word),
        .ctrl     (ctrl),
        .rdata    (reg_rdata),
        .tx_start (tx_start),
        .osr_en   (osr_en)
    );

    mmser_tx #(.OSR(OSR)) u_tx (
        .clk    (clk),
        .rst    (rst),
        .osr_en (osr_en),
        .start  (tx_start),
        .nine   (has_ninth(ctrl.mode)),
        .tb8    (ctrl.tx_ninth),
        .data   (reg_wdata),
        .txd    (ser_tx),
        .busy   (tx_busy),
        .done   (tx_done)
    );

    mmser_rx #(.OSR(OSR)) u_rx (
        .clk    (clk),
        .rst    (rst),
        .osr_en (osr_en),
        .en     (ctrl.rx_en && (ctrl.mode != MODE_OFF)),
        .nine   (has_ninth(ctrl.mode)),
        .rxd    (ser_rx),
        .valid  (rx_valid),
        .word   (rx_word)
    );

    p_mode_off_r3: assert property (@(posedge clk) disable iff (rst)
        (ctrl.mode == MODE_OFF && !tx_busy) |=> !tx_busy);

endmodule

// File: tb/test_mmserial_port.sv
module test_mmserial_port;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       os_tick = 1'b1;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       ser_tx;
    logic       drv = 1'b1;
    logic       loop = 1'b1;
    logic       ser_rx;
    logic [7:0] cur = 8'd0;
    int         total = 0;
    int         bad = 0;
    bit         finished = 1'b0;

    assign ser_rx = loop ? ser_tx : drv;

    always #2.5 clk = ~clk;

    mmserial_port i_mmserial_port (
        .clk(clk), .rst(rst), .os_tick(os_tick), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ser_rx(ser_rx), .ser_tx(ser_tx)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic tx_decode(input int nb, input int per, output logic [10:0] fr);
        fr = '1;
        repeat (per / 2) @(negedge clk);
        for (int k = 0; k < nb; k++) begin
            fr[k] = ser_tx;
            repeat (per) @(negedge clk);
        end
    endtask

    // Loopback one byte: checks line format, flags, ninth bit and buffer
    task automatic loop_byte(input logic [7:0] d, input logic nine, input int per);
        logic [10:0] fr, ex;
        logic [7:0]  v;
        int          nb;
        logic        tb8;
        tb8 = cur[3];
        nb  = nine ? 11 : 10;
        ex  = nine ? {1'b1, tb8, d, 1'b0} : {2'b11, d, 1'b0};
        wr(2'd1, d);
        tx_decode(nb, per, fr);
        chk(fr == ex, "R2 frame", int'(fr), int'(ex));
        rd(2'd0, v);
        chk(v[1] == 1'b1, "R4 tx_done", int'(v[1]), 1);
        chk(v[0] == 1'b1, "R5 rx_done", int'(v[0]), 1);
        chk(v[2] == (nine ? tb8 : 1'b1), "R6 rb8", int'(v[2]), int'(nine ? tb8 : 1'b1));
        rd(2'd1, v);
        chk(v == d, "R5 buffer", int'(v), int'(d));
        wr(2'd0, cur);
    endtask

    // Drive a frame from the bench; optional one-clock glitch mid data bit
    task automatic drive_frame(input logic [10:0] bits, input int nb, input int per, input bit glitch);
        for (int k = 0; k < nb; k++) begin
            @(negedge clk);
            drv = bits[k];
            if (glitch && k > 0 && k < nb - 1) begin
                repeat (per / 2) @(negedge clk);
                drv = ~bits[k];
                @(negedge clk);
                drv = bits[k];
                repeat (per / 2 - 2) @(negedge clk);
            end else begin
                repeat (per - 1) @(negedge clk);
            end
        end
        @(negedge clk);
        drv = 1'b1;
        repeat (3 * per) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, keep;
        int         lowcnt;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(2'd0, v); chk(v == 8'h00, "R1 ctrl", int'(v), 0);
        rd(2'd1, v); chk(v == 8'h00, "R1 buffer", int'(v), 0);
        rd(2'd2, v); chk(v == 8'h00, "R1 rate", int'(v), 0);
        chk(ser_tx == 1'b1, "R1 txd", int'(ser_tx), 1);

        // R11 doubled rate, then full 8-bit sweep
        wr(2'd2, 8'h01);
        rd(2'd2, v); chk(v == 8'h01, "R11 rate readback", int'(v), 1);
        cur = 8'h50; wr(2'd0, cur);
        for (int b = 0; b < 256; b++) loop_byte(8'(b), 1'b0, 16);

        // R2 R6 9-bit modes, both ninth-bit values
        for (int b = 0; b < 64; b++) begin
            cur = 8'hD0 | (8'(b & 1) << 3); wr(2'd0, cur);
            loop_byte(8'(b * 37 + 5), 1'b1, 16);
        end
        for (int b = 0; b < 4; b++) begin
            cur = 8'h90 | (8'(b & 1) << 3); wr(2'd0, cur);
            loop_byte(8'(b * 91 + 3), 1'b1, 16);
        end

        // R8 multiprocessor filter in a 9-bit mode
        rd(2'd1, keep);
        cur = 8'hF0; wr(2'd0, cur);
        wr(2'd1, 8'h5A);
        repeat (260) @(negedge clk);
        rd(2'd0, v); chk(v[0] == 1'b0, "R8 ninth=0 dropped", int'(v[0]), 0);
        rd(2'd1, v); chk(v == keep, "R8 buffer kept", int'(v), int'(keep));
        cur = 8'hF8; wr(2'd0, cur);
        loop_byte(8'hC3, 1'b1, 16);

        // R6 R8 stop-bit handling in 8-bit mode, bench-driven line
        loop = 1'b0;
        rd(2'd1, keep);
        cur = 8'h70; wr(2'd0, cur);
        drive_frame({2'b00, 8'h96, 1'b0}, 10, 16, 1'b0);
        rd(2'd0, v); chk(v[0] == 1'b0, "R8 bad stop dropped", int'(v[0]), 0);
        rd(2'd1, v); chk(v == keep, "R8 buffer kept", int'(v), int'(keep));
        cur = 8'h50; wr(2'd0, cur);
        drive_frame({2'b00, 8'h96, 1'b0}, 10, 16, 1'b0);
        rd(2'd0, v);
        chk(v[0] == 1'b1, "R6 bad stop accepted", int'(v[0]), 1);
        chk(v[2] == 1'b0, "R6 rb8 holds stop", int'(v[2]), 0);
        rd(2'd1, v); chk(v == 8'h96, "R6 buffer", int'(v), 8'h96);

        // R9 overrun: receive-done still set
        drive_frame({2'b11, 8'h21, 1'b0}, 10, 16, 1'b0);
        rd(2'd1, v); chk(v == 8'h96, "R9 buffer kept", int'(v), 8'h96);
        wr(2'd0, cur);

        // R7 receiver disabled
        cur = 8'h40; wr(2'd0, cur);
        drive_frame({2'b11, 8'h44, 1'b0}, 10, 16, 1'b0);
        rd(2'd0, v); chk(v[0] == 1'b0, "R7 no rx_done", int'(v[0]), 0);
        rd(2'd1, v); chk(v == 8'h96, "R7 buffer kept", int'(v), 8'h96);
        cur = 8'h10; wr(2'd0, cur);
        drive_frame({2'b11, 8'h44, 1'b0}, 10, 16, 1'b0);
        rd(2'd0, v); chk(v[0] == 1'b0, "R7 mode00 no rx_done", int'(v[0]), 0);

        // R10 short start pulse rejected
        cur = 8'h50; wr(2'd0, cur);
        @(negedge clk); drv = 1'b0;
        repeat (3) @(negedge clk); drv = 1'b1;
        repeat (300) @(negedge clk);
        rd(2'd0, v); chk(v[0] == 1'b0, "R10 false start", int'(v[0]), 0);
        drive_frame({2'b11, 8'hE7, 1'b0}, 10, 16, 1'b0);
        rd(2'd1, v); chk(v == 8'hE7, "R10 next frame", int'(v), 8'hE7);
        wr(2'd0, cur);

        // R12 one-clock glitch in every data bit
        drive_frame({2'b11, 8'h5C, 1'b0}, 10, 16, 1'b1);
        rd(2'd1, v); chk(v == 8'h5C, "R12 glitch vote", int'(v), 8'h5C);
        wr(2'd0, cur);
        loop = 1'b1;

        // R3 write while busy ignored
        wr(2'd1, 8'h3C);
        repeat (40) @(negedge clk);
        wr(2'd1, 8'hFF);
        repeat (200) @(negedge clk);
        rd(2'd1, v); chk(v == 8'h3C, "R3 busy write", int'(v), 8'h3C);
        wr(2'd0, cur);
        repeat (200) @(negedge clk);
        rd(2'd0, v); chk(v[1] == 1'b0, "R3 no second frame", int'(v[1]), 0);

        // R3 mode 00 never sends
        cur = 8'h10; wr(2'd0, cur);
        wr(2'd1, 8'h00);
        lowcnt = 0;
        for (int n = 0; n < 200; n++) begin
            @(negedge clk);
            if (!ser_tx) lowcnt++;
        end
        chk(lowcnt == 0, "R3 mode00 line", lowcnt, 0);
        rd(2'd0, v); chk(v[1] == 1'b0, "R3 mode00 tx_done", int'(v[1]), 0);

        // R11 start-bit length at both rates
        cur = 8'h50; wr(2'd0, cur);
        for (int r = 0; r < 2; r++) begin
            wr(2'd2, 8'(r));
            wr(2'd1, 8'hFF);
            lowcnt = 0;
            while (!ser_tx && lowcnt < 100) begin
                lowcnt++;
                @(negedge clk);
            end
            chk(lowcnt >= (r ? 15 : 31) && lowcnt <= (r ? 17 : 33),
                "R11 bit length", lowcnt, r ? 16 : 32);
            repeat (400) @(negedge clk);
            wr(2'd0, cur);
        end
        wr(2'd2, 8'h00);
        loop_byte(8'hA5, 1'b0, 32);
        loop_byte(8'h18, 1'b0, 32);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule